// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is an 8-bit up-counter that produces two pulse-width modulated waveforms, channel A and channel B, in single-slope mode. The counter climbs by one on every count-enable pulse from a built-in clock divider. When it equals its ceiling (TOP) it returns to zero on the next pulse. TOP is either the all-ones value or the active compare value of channel A, picked by one input bit. Each channel compares the count against its own active compare value. A 2-bit mode field sets whether the pin is non-inverted, inverted, toggling (channel A only) or held low.

The compare inputs act as a staging buffer. Their values are copied into the active compare registers only on the count-enable pulse at which the counter wraps from TOP to zero, so a compare value changed in mid-period never cuts a pulse short. Three sticky flags record the wrap and each channel's compare match. Each flag has its own clear strobe.

Each channel's pin level comes from a two-state machine with states `LVL_LOW` and `LVL_HIGH`. Each transition happens on a count-enable pulse:
- Non-inverted: `LVL_LOW -> LVL_HIGH` on wrap, `LVL_HIGH -> LVL_LOW` on match without wrap.
- Inverted: `LVL_LOW -> LVL_HIGH` on match without wrap, `LVL_HIGH -> LVL_LOW` on wrap.
- Toggle: either state moves to the other on match.
- Held low: the state stays where it is.

Top module: `fpwm_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count, all three flags and both waveform pins are 0 after that edge.
- R2: With `top_from_a` = 0, the count goes up by one per count-enable pulse up to 255, and the pulse taken at 255 brings it back to 0.
- R3: `clk_sel` codes 1, 2, 3, 4 and 5 give one count-enable pulse every 1, 8, 64, 256 and 1024 clocks, starting from reset. Codes 0, 6 and 7 stop the divider and freeze the count.
- R4: With `top_from_a` = 1, TOP is channel A's active compare value: the count wraps to 0 on the pulse taken at that value.
- R5: `ovf_flag` sets on the pulse at which the count wraps from TOP and stays set until `clr_ovf` is high at a clock edge. If the set and the clear fall on the same edge, the flag ends up set.
- R6: A channel's match flag sets on the pulse taken while the count equals that channel's active compare value. It stays set until its clear strobe is high at an edge, and a set wins over a simultaneous clear.
- R7: Mode 2 (non-inverted): the pin is high while the count is 0 up to the compare value C, and low for the rest of the period, which is C+1 high pulses out of 256. With C = 255 the pin is constantly high.
- R8: Mode 3 (inverted): the pin is low while the count is 0 up to C and high above it, which is 255-C high pulses out of 256. With C = 255 the pin is constantly low.
- R9: In mode 2, a compare value of 0 gives a high spike one count-enable pulse long in every 256-pulse period.
- R10: Mode 1 on channel A with `top_from_a` = 1 inverts pin A at every compare match. Mode 1 on channel A with `top_from_a` = 0, mode 1 on channel B, and mode 0 on either channel all hold the pin at 0.
- R11: A new compare input value takes effect only at the next wrap from TOP to 0. Until that wrap, the match position in the current period stays where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Divider select: 0 stop, 1..5 divide by 1/8/64/256/1024, 6..7 stop |
| top_from_a | input | 1 | 0: TOP is 255; 1: TOP is channel A's active compare value |
| cmp_a | input | 8 | Staged compare value, channel A |
| cmp_b | input | 8 | Staged compare value, channel B |
| mode_a | input | 2 | Pin mode, channel A: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| mode_b | input | 2 | Pin mode, channel B: 0 off, 1 off, 2 non-inverted, 3 inverted |
| clr_ovf | input | 1 | Clear strobe for the wrap flag |
| clr_match_a | input | 1 | Clear strobe for channel A's match flag |
| clr_match_b | input | 1 | Clear strobe for channel B's match flag |
| wave_a | output | 1 | Waveform pin, channel A |
| wave_b | output | 1 | Waveform pin, channel B |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| match_a_flag | output | 1 | Sticky compare-match flag, channel A |
| match_b_flag | output | 1 | Sticky compare-match flag, channel B |

## Verification
The properties assume that `top_from_a` does not drop TOP below the current count while the counter is running. Under that assumption, every step of the count is either +1, a hold, or a return to zero, and a rising wrap flag always sees a count of 0. The stimulus changes `top_from_a` and `clk_sel` only while reset is asserted, or while the count is already below the new ceiling. All inputs are driven on the falling clock edge, so every input is stable at each rising edge where the design samples it.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    // Pin mode encoding shared by both channels
    typedef enum logic [1:0] {
        WM_OFF    = 2'd0,
        WM_TOGGLE = 2'd1,
        WM_NONINV = 2'd2,
        WM_INV    = 2'd3
    } wave_mode_e;

    // Level state of a channel's waveform machine
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // Divider select codes
    localparam logic [2:0] SEL_DIV1    = 3'd1;
    localparam logic [2:0] SEL_DIV8    = 3'd2;
    localparam logic [2:0] SEL_DIV64   = 3'd3;
    localparam logic [2:0] SEL_DIV256  = 3'd4;
    localparam logic [2:0] SEL_DIV1024 = 3'd5;

    // Division factors
    localparam int DIV_F1 = 8;
    localparam int DIV_F2 = 64;
    localparam int DIV_F3 = 256;
    localparam int DIV_F4 = 1024;

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler
    import fpwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             run;

    // Mask of low divider bits that must all be one for a pulse
    always_comb begin
        run  = 1'b1;
        mask = '0;
        unique case (sel)
            SEL_DIV1:    mask = '0;
            SEL_DIV8:    mask = PRE_W'(DIV_F1 - 1);
            SEL_DIV64:   mask = PRE_W'(DIV_F2 - 1);
            SEL_DIV256:  mask = PRE_W'(DIV_F3 - 1);
            SEL_DIV1024: mask = PRE_W'(DIV_F4 - 1);
            default:     run  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && ((pre_q & mask) == mask);

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic [CNT_W-1:0] count_q;
    logic             at_top;

    assign at_top = (count_q == top_val);
    assign wrap   = tick && at_top;
    assign count  = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= at_top ? '0 : count_q + 1'b1;
        end
    end

endmodule

// File: rtl/fpwm_flag.sv
module fpwm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [1:0]       mode_in,
    input  logic             toggle_ok,
    output logic [CNT_W-1:0] cmp_active,
    output logic             hit,
    output logic             wave
);

    wave_mode_e       mode;
    level_e           lvl_q;
    level_e           lvl_d;
    logic [CNT_W-1:0] act_q;
    logic             toggle_en;
    logic             driven;

    assign mode       = wave_mode_e'(mode_in);
    assign toggle_en  = (mode == WM_TOGGLE) && toggle_ok;
    assign hit        = tick && (count == act_q);
    assign cmp_active = act_q;

    // Staged compare value is copied in only at the wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (wrap) begin
            act_q <= cmp_in;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // Next-state logic: the wrap wins over a match in the same pulse
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW: begin
                if (mode == WM_NONINV && wrap) begin
                    lvl_d = LVL_HIGH;
                end else if (mode == WM_INV && hit && !wrap) begin
                    lvl_d = LVL_HIGH;
                end else if (toggle_en && hit) begin
                    lvl_d = LVL_HIGH;
                end
            end
            LVL_HIGH: begin
                if (mode == WM_NONINV && hit && !wrap) begin
                    lvl_d = LVL_LOW;
                end else if (mode == WM_INV && wrap) begin
                    lvl_d = LVL_LOW;
                end else if (toggle_en && hit) begin
                    lvl_d = LVL_LOW;
                end
            end
            default: lvl_d = LVL_LOW;
        endcase
    end

    // Output logic
    always_comb begin
        driven = (mode == WM_NONINV) || (mode == WM_INV) || toggle_en;
        wave   = driven && (lvl_q == LVL_HIGH);
    end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       clk_sel,
    input  logic             top_from_a,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic             clr_ovf,
    input  logic             clr_match_a,
    input  logic             clr_match_b,
    output logic             wave_a,
    output logic             wave_b,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             match_a_flag,
    output logic             match_b_flag
);

    localparam int               NCH     = 2;
    localparam int               CH_A    = 0;
    localparam int               CH_B    = 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] top_val;

    logic [CNT_W-1:0] cmp_arr  [NCH];
    logic [1:0]       mode_arr [NCH];
    logic             clr_arr  [NCH];
    logic             tog_ok   [NCH];
    logic [CNT_W-1:0] act_arr  [NCH];
    logic             hit_arr  [NCH];
    logic             wave_arr [NCH];
    logic             flag_arr [NCH];

    assign cmp_arr[CH_A]  = cmp_a;
    assign cmp_arr[CH_B]  = cmp_b;
    assign mode_arr[CH_A] = mode_a;
    assign mode_arr[CH_B] = mode_b;
    assign clr_arr[CH_A]  = clr_match_a;
    assign clr_arr[CH_B]  = clr_match_b;

    assign top_val = top_from_a ? act_arr[CH_A] : CNT_MAX;

    fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .top_val (top_val),
        .count   (count),
        .wrap    (wrap)
    );

    fpwm_flag u_ovf (
        .clk (clk),
        .rst (rst),
        .set (wrap),
        .clr (clr_ovf),
        .q   (ovf_flag)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        // Toggle mode exists only on the channel that can define TOP
        assign tog_ok[gi] = (gi == CH_A) ? top_from_a : 1'b0;

        fpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .wrap       (wrap),
            .count      (count),
            .cmp_in     (cmp_arr[gi]),
            .mode_in    (mode_arr[gi]),
            .toggle_ok  (tog_ok[gi]),
            .cmp_active (act_arr[gi]),
            .hit        (hit_arr[gi]),
            .wave       (wave_arr[gi])
        );

        fpwm_flag u_mflag (
            .clk (clk),
            .rst (rst),
            .set (hit_arr[gi]),
            .clr (clr_arr[gi]),
            .q   (flag_arr[gi])
        );
    end

    assign wave_a       = wave_arr[CH_A];
    assign wave_b       = wave_arr[CH_B];
    assign match_a_flag = flag_arr[CH_A];
    assign match_b_flag = flag_arr[CH_B];

endmodule

// File: rtl/fpwm_timer_checker.sv
module fpwm_timer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       clk_sel,
    input logic             top_from_a,
    input logic [1:0]       mode_a,
    input logic [1:0]       mode_b,
    input logic             clr_ovf,
    input logic             clr_match_a,
    input logic             clr_match_b,
    input logic             wave_a,
    input logic             wave_b,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             match_a_flag,
    input logic             match_b_flag
);

    // R1: reset clears the visible state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf_flag && !match_a_flag && !match_b_flag && !wave_a && !wave_b));

    // R2: count only holds, steps by one, or returns to zero
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

    // R3: stop codes freeze the count
    a_r3_halt: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'd0 || clk_sel > 3'd5) |=> $stable(count));

    // R5: wrap flag is sticky without a clear
    a_r5_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    // R5: wrap flag only rises as the count lands on zero
    a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (count == '0));

    // R6: match flags are sticky without a clear
    a_r6_match_a_hold: assert property (@(posedge clk) disable iff (rst)
        (match_a_flag && !clr_match_a) |=> match_a_flag);

    a_r6_match_b_hold: assert property (@(posedge clk) disable iff (rst)
        (match_b_flag && !clr_match_b) |=> match_b_flag);

    // R10: mode 1 on channel B never drives the pin
    a_r10_b_no_toggle: assert property (@(posedge clk) disable iff (rst)
        (mode_b == 2'd1) |-> !wave_b);

    // R10: toggle on channel A needs TOP taken from channel A
    a_r10_a_gated: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'd1 && !top_from_a) |-> !wave_a);

endmodule

bind fpwm_timer fpwm_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_sel      (clk_sel),
    .top_from_a   (top_from_a),
    .mode_a       (mode_a),
    .mode_b       (mode_b),
    .clr_ovf      (clr_ovf),
    .clr_match_a  (clr_match_a),
    .clr_match_b  (clr_match_b),
    .wave_a       (wave_a),
    .wave_b       (wave_b),
    .count        (count),
    .ovf_flag     (ovf_flag),
    .match_a_flag (match_a_flag),
    .match_b_flag (match_b_flag)
);

// File: tb/fpwm_timer_bench.sv
module fpwm_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    // Row: {mode[1:0], cmp[7:0], expected high pulses per 256 [8:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd2, 8'd0,   9'd1},    // R9 spike
        {2'd2, 8'd100, 9'd101},  // R7
        {2'd2, 8'd127, 9'd128},  // R7
        {2'd2, 8'd255, 9'd256},  // R7 max
        {2'd3, 8'd0,   9'd255},  // R8
        {2'd3, 8'd100, 9'd155},  // R8
        {2'd3, 8'd255, 9'd0},    // R8 max
        {2'd0, 8'd100, 9'd0},    // R10 off
        {2'd1, 8'd100, 9'd0}     // R10 no toggle with fixed TOP
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] clk_sel = 3'd1;
    logic       top_from_a = 1'b0;
    logic [7:0] cmp_a = '0;
    logic [7:0] cmp_b = '0;
    logic [1:0] mode_a = '0;
    logic [1:0] mode_b = '0;
    logic       clr_ovf = 1'b0;
    logic       clr_match_a = 1'b0;
    logic       clr_match_b = 1'b0;
    logic       wave_a;
    logic       wave_b;
    logic [7:0] count;
    logic       ovf_flag;
    logic       match_a_flag;
    logic       match_b_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpwm_timer u_fpwm_timer (
        .clk          (clk),
        .rst          (rst),
        .clk_sel      (clk_sel),
        .top_from_a   (top_from_a),
        .cmp_a        (cmp_a),
        .cmp_b        (cmp_b),
        .mode_a       (mode_a),
        .mode_b       (mode_b),
        .clr_ovf      (clr_ovf),
        .clr_match_a  (clr_match_a),
        .clr_match_b  (clr_match_b),
        .wave_a       (wave_a),
        .wave_b       (wave_b),
        .count        (count),
        .ovf_flag     (ovf_flag),
        .match_a_flag (match_a_flag),
        .match_b_flag (match_b_flag)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_count(input int v);
        while (int'(count) != v) @(negedge clk);
    endtask

    task automatic count_highs(input int n, output int ha, output int hb);
        ha = 0;
        hb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(wave_a);
            hb += int'(wave_b);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ha, hb, maxc, snap;

        // R1: reset state
        mode_a = 2'd3;
        mode_b = 2'd3;
        repeat (3) @(negedge clk);
        check("R1 count", count, 0);
        check("R1 flags", {ovf_flag, match_a_flag, match_b_flag}, 0);
        check("R1 pins", {wave_a, wave_b}, 0);

        // Duty table for R7, R8, R9, R10
        for (int r = 0; r < NVEC; r++) begin
            mode_a = VEC[r][18:17];
            mode_b = VEC[r][18:17];
            cmp_a  = VEC[r][16:9];
            cmp_b  = VEC[r][16:9];
            clk_sel = 3'd1;
            top_from_a = 1'b0;
            do_reset();
            repeat (300) @(negedge clk);
            count_highs(256, ha, hb);
            check($sformatf("R7/R8/R9/R10 row %0d pin A", r), ha, int'(VEC[r][8:0]));
            check($sformatf("R7/R8/R9/R10 row %0d pin B", r), hb, int'(VEC[r][8:0]));
        end

        // R2: counting and wrap at 255
        mode_a = 2'd0;
        mode_b = 2'd0;
        cmp_a = 8'd50;
        cmp_b = 8'd20;
        do_reset();
        repeat (10) @(negedge clk);
        check("R2 count after 10", count, 10);
        repeat (245) @(negedge clk);
        check("R2 count at 255", count, 255);
        check("R5 no flag before wrap", ovf_flag, 0);
        @(negedge clk);
        check("R2 wrap to 0", count, 0);
        check("R5 flag set at wrap", ovf_flag, 1);

        // R5: clear and set-wins
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R5 cleared", ovf_flag, 0);
        repeat (20) @(negedge clk);
        check("R5 stays clear", ovf_flag, 0);
        wait_count(255);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R5 set wins over clear", ovf_flag, 1);

        // R6: match flags (active values are 50 and 20 now)
        clr_match_a = 1'b1;
        clr_match_b = 1'b1;
        @(negedge clk);
        clr_match_a = 1'b0;
        clr_match_b = 1'b0;
        check("R6 A cleared", match_a_flag, 0);
        wait_count(50);
        check("R6 A not yet set at count 50", match_a_flag, 0);
        check("R6 B set after count 20", match_b_flag, 1);
        clr_match_a = 1'b1;
        @(negedge clk);
        clr_match_a = 1'b0;
        check("R6 A set wins over clear", match_a_flag, 1);

        // R11: staged compare value waits for the wrap
        mode_a = 2'd2;
        cmp_a = 8'd50;
        do_reset();
        repeat (300) @(negedge clk);
        wait_count(10);
        cmp_a = 8'd200;
        wait_count(100);
        check("R11 old compare still active", wave_a, 0);
        wait_count(255);
        wait_count(100);
        check("R11 new compare after wrap", wave_a, 1);

        // R4: TOP taken from channel A
        mode_a = 2'd0;
        cmp_a = 8'd9;
        top_from_a = 1'b1;
        do_reset();
        maxc = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (int'(count) > maxc) maxc = int'(count);
        end
        check("R4 max count equals cmp A", maxc, 9);
        wait_count(9);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R4 wrap after cmp A", count, 0);

        // R10: toggle on A with TOP from A; B mode 1 stays low
        mode_a = 2'd1;
        mode_b = 2'd1;
        cmp_b = 8'd5;
        do_reset();
        repeat (20) @(negedge clk);
        count_highs(100, ha, hb);
        check("R10 A toggles half the time", ha, 50);
        check("R10 B mode 1 held low", hb, 0);
        wait_count(3);
        top_from_a = 1'b0;
        count_highs(100, ha, hb);
        check("R10 A toggle gated by TOP select", ha, 0);

        // R3: divider ratios from reset
        mode_a = 2'd0;
        mode_b = 2'd0;
        clk_sel = 3'd2;
        do_reset();
        repeat (80) @(negedge clk);
        check("R3 divide by 8", count, 10);
        clk_sel = 3'd3;
        do_reset();
        repeat (640) @(negedge clk);
        check("R3 divide by 64", count, 10);
        clk_sel = 3'd4;
        do_reset();
        repeat (2560) @(negedge clk);
        check("R3 divide by 256", count, 10);
        clk_sel = 3'd5;
        do_reset();
        repeat (3072) @(negedge clk);
        check("R3 divide by 1024", count, 3);
        clk_sel = 3'd0;
        snap = int'(count);
        repeat (50) @(negedge clk);
        check("R3 code 0 stops", count, snap);
        clk_sel = 3'd7;
        repeat (50) @(negedge clk);
        check("R3 code 7 stops", count, snap);
        clk_sel = 3'd1;
        repeat (5) @(negedge clk);
        check("R3 divide by 1 resumes", count, snap + 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule